// File: doc/BRIEF.md
# ADC Conversion Sequencer and Register Front End

This block is the digital half of a 10-bit successive-approximation converter. Software reaches it through a small 8-bit register bus with four byte addresses: a selection register, a control/status register, and the low and high bytes of the result. It divides the system clock into a converter tick, counts the ticks of each conversion, and holds the channel and reference selection steady while a conversion runs. At the end of a conversion it captures a 10-bit code, raises a completion flag and, if enabled, an interrupt request.

The analog comparator and DAC are not modelled. The bench supplies the finished code on a digital sample port, and the block captures that port on the tick that ends the conversion. A conversion starts on a software write, on a rising edge of a trigger input, or by restarting itself in free-running mode.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, all bytes at address 0 (selection) and address 1 (control) read 0x00 and `irq`, `chan_sel` and `ref_sel` are low. Bits 7:5 of the selection register always read zero. Its layout is [1:0] channel, [2] reference, [3] left-adjust and [4] free-run.
- R2: `chan_sel` and `ref_sel` take the register value when a conversion starts. A write to the selection register during a conversion reads back at once, but it reaches `chan_sel`/`ref_sel` only in the second cycle after the conversion ends.
- R3: Left-adjust (selection bit 3) changes the data bytes at once. When set, the high byte is code[9:2] and the low byte is {code[1:0], 6'b0}. When clear, the low byte is code[7:0] and the high byte is {6'b0, code[9:8]}.
- R4: The control layout is [7] enable, [6] start/busy, [5] auto-trigger, [4] flag, [3] interrupt enable and [2:0] prescale. Writing 1 to bit 6 while enabled starts a conversion. Bit 6 reads 1 for exactly the length of the conversion and reads 0 afterwards. Writing 0 to it starts nothing.
- R5: A conversion lasts 13 ticks. The first conversion after the enable bit goes from 0 to 1 lasts 25 ticks, including when enable and start are written together.
- R6: Writing enable to 0 during a conversion aborts it. The result bytes are unchanged, the flag stays 0 and busy returns to 0.
- R7: When a conversion ends, the sampled code is stored and the flag is set in the cycle that busy falls. `irq` is high exactly when the flag and the interrupt enable are both 1.
- R8: The flag is cleared by a control write with bit 4 set, or by a one-cycle pulse on `irq_ack`. A control write with bit 4 clear leaves the flag as it was.
- R9: With auto-trigger set and the block idle, a rising edge on `trig_in` starts one conversion. Holding `trig_in` high does not start another.
- R10: With free-run and auto-trigger both set, one software start launches conversions back to back. Busy is low for one cycle between conversions, and each conversion after the first lasts 13 ticks.
- R11: The prescale values 0 through 7 give one tick every 2, 2, 4, 8, 16, 32, 64 or 128 system clocks. The tick counter restarts at each conversion, so a conversion lasts ticks × divisor clocks.
- R12: Reading the low byte (address 2 with `bus_rd`) freezes the high byte (address 3). Later completions do not change it until the high byte is read once. After that the high byte follows the live result again.
- R13: The full code range is stored without change: 0x000 reads as 0x00/0x00 and 0x3FF reads as 0xFF/0x03 when right-adjusted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on result bytes) |
| bus_addr | input | 2 | Byte address: 0 select, 1 control, 2 result low, 3 result high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| trig_in | input | 1 | Auto-trigger source, rising-edge sensitive |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| sample_code | input | 10 | Converted code from the behavioural analog model |
| chan_sel | output | 2 | Active input channel |
| ref_sel | output | 1 | Active reference select |
| irq | output | 1 | Conversion-complete interrupt request |

## Verification
A tick counter or length selector in the wrong state shows up at once as a busy window of the wrong length, measured to the cycle at the control register, for example 50 clocks in place of 26. A broken hold of the selection shows up at `chan_sel`/`ref_sel` during the first cycle after the start. A stale first-conversion marker shows up only at the next conversion, which then has the wrong length. Errors in the flag or the result capture show up at the data and control bytes in the first cycle after busy falls. Corruption of the freeze state stays hidden until the high byte is read after a later completion.

// File: rtl/adc_pkg.sv
package adc_pkg;

  localparam int BUS_W = 8;

  localparam logic [1:0] ADDR_SEL  = 2'd0;
  localparam logic [1:0] ADDR_CTL  = 2'd1;
  localparam logic [1:0] ADDR_DLO  = 2'd2;
  localparam logic [1:0] ADDR_DHI  = 2'd3;

  // control register bit positions
  localparam int CTL_EN    = 7;
  localparam int CTL_GO    = 6;
  localparam int CTL_AUTO  = 5;
  localparam int CTL_FLAG  = 4;
  localparam int CTL_IE    = 3;

  // selection register bit positions
  localparam int SEL_REF   = 2;
  localparam int SEL_LADJ  = 3;
  localparam int SEL_FRUN  = 4;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/adc_tick_div.sv
module adc_tick_div #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);

  localparam int CNT_W = (1 << PS_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim;

  always_comb begin
    if (ps == '0) lim = CNT_W'(1);
    else          lim = CNT_W'((32'd1 << ps) - 32'd1);
  end

  assign tick = run && (cnt_q == lim);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R11
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/adc_seq_core.sv
module adc_seq_core
  import adc_pkg::*;
#(
  parameter int SHORT_LEN = 13,
  parameter int LONG_LEN  = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done
);

  localparam int STEP_W = $clog2(LONG_LEN + 1);
  localparam logic [STEP_W-1:0] SHORT_LAST = STEP_W'(SHORT_LEN - 1);
  localparam logic [STEP_W-1:0] LONG_LAST  = STEP_W'(LONG_LEN - 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              first_pend_q, first_pend_d;
  logic              is_long_q, is_long_d;
  logic [STEP_W-1:0] last_step;

  assign last_step = is_long_q ? LONG_LAST : SHORT_LAST;
  assign busy      = (state_q == SEQ_RUN);
  assign done      = busy && en && tick && (step_q == last_step);

  always_comb begin
    state_d      = state_q;
    step_d       = step_q;
    is_long_d    = is_long_q;
    first_pend_d = first_pend_q;

    if (start)    first_pend_d = 1'b0;
    else if (!en) first_pend_d = 1'b1;

    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d   = SEQ_RUN;
          step_d    = '0;
          is_long_d = first_pend_q;
        end
      end
      SEQ_RUN: begin
        if (!en || done) begin
          state_d = SEQ_IDLE;
          step_d  = '0;
        end else if (tick) begin
          step_d = step_q + STEP_W'(1);
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SEQ_IDLE;
      step_q       <= '0;
      is_long_q    <= 1'b0;
      first_pend_q <= 1'b1;
    end else begin
      state_q      <= state_d;
      step_q       <= step_d;
      is_long_q    <= is_long_d;
      first_pend_q <= first_pend_d;
    end
  end

  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !en |=> !busy);

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && en && !done |=> busy);

  // R5
  step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> step_q <= LONG_LAST);

endmodule

// File: rtl/adc_result_fmt.sv
module adc_result_fmt #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  code,
  input  logic              left,
  output logic [BYTE_W-1:0] hi,
  output logic [BYTE_W-1:0] lo
);

  localparam int PAIR_W = 2 * BYTE_W;
  localparam int PAD_W  = PAIR_W - RES_W;

  logic [PAIR_W-1:0] pair;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        if (left) pair = {code, {PAD_W{1'b0}}};
        else      pair = {{PAD_W{1'b0}}, code};
      end
    end else begin : g_nopad
      always_comb pair = PAIR_W'(code);
    end
  endgenerate

  assign hi = pair[PAIR_W-1:BYTE_W];
  assign lo = pair[BYTE_W-1:0];

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_pkg::*;
#(
  parameter int RES_W     = 10,
  parameter int SHORT_LEN = 13,
  parameter int LONG_LEN  = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             trig_in,
  input  logic             irq_ack,
  input  logic [RES_W-1:0] sample_code,
  output logic [1:0]       chan_sel,
  output logic             ref_sel,
  output logic             irq
);

  localparam int PS_W = 3;

  // selection register
  logic [1:0] chan_q, chan_d;
  logic       ref_q, ref_d, ladj_q, ladj_d, frun_q, frun_d;
  // control register
  logic            en_q, en_d, auto_q, auto_d, flag_q, flag_d, ie_q, ie_d;
  logic [PS_W-1:0] ps_q, ps_d;
  // sequencing and result state
  logic             trig_q, restart_q, restart_d;
  logic [RES_W-1:0] result_q, result_d, hold_q, hold_d;
  logic             hold_vld_q, hold_vld_d;
  logic [1:0]       chan_act_q, chan_act_d;
  logic             ref_act_q, ref_act_d;

  logic wr_sel, wr_ctl, rd_lo, rd_hi;
  logic sw_start, trig_edge, start_go;
  logic seq_busy, seq_done, tick;
  logic [BUS_W-1:0] live_hi, live_lo, held_hi, held_lo;

  assign wr_sel    = bus_wr && (bus_addr == ADDR_SEL);
  assign wr_ctl    = bus_wr && (bus_addr == ADDR_CTL);
  assign rd_lo     = bus_rd && (bus_addr == ADDR_DLO);
  assign rd_hi     = bus_rd && (bus_addr == ADDR_DHI);
  assign sw_start  = wr_ctl && bus_wdata[CTL_GO];
  assign trig_edge = trig_in && !trig_q;
  assign start_go  = en_d && !seq_busy &&
                     (sw_start || (auto_q && en_q && trig_edge) || restart_q);

  adc_tick_div #(.PS_W(PS_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (seq_busy && en_q),
    .ps    (ps_q),
    .tick  (tick)
  );

  adc_seq_core #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_q),
    .start (start_go),
    .tick  (tick),
    .busy  (seq_busy),
    .done  (seq_done)
  );

  adc_result_fmt #(.RES_W(RES_W), .BYTE_W(BUS_W)) u_fmt_live (
    .code (result_q),
    .left (ladj_q),
    .hi   (live_hi),
    .lo   (live_lo)
  );

  adc_result_fmt #(.RES_W(RES_W), .BYTE_W(BUS_W)) u_fmt_held (
    .code (hold_q),
    .left (ladj_q),
    .hi   (held_hi),
    .lo   (held_lo)
  );

  // register next-state
  always_comb begin
    chan_d = chan_q;
    ref_d  = ref_q;
    ladj_d = ladj_q;
    frun_d = frun_q;
    if (wr_sel) begin
      chan_d = bus_wdata[1:0];
      ref_d  = bus_wdata[SEL_REF];
      ladj_d = bus_wdata[SEL_LADJ];
      frun_d = bus_wdata[SEL_FRUN];
    end

    en_d   = en_q;
    auto_d = auto_q;
    ie_d   = ie_q;
    ps_d   = ps_q;
    if (wr_ctl) begin
      en_d   = bus_wdata[CTL_EN];
      auto_d = bus_wdata[CTL_AUTO];
      ie_d   = bus_wdata[CTL_IE];
      ps_d   = bus_wdata[PS_W-1:0];
    end

    if (seq_done)                                  flag_d = 1'b1;
    else if ((wr_ctl && bus_wdata[CTL_FLAG]) || irq_ack) flag_d = 1'b0;
    else                                           flag_d = flag_q;

    restart_d = seq_done && auto_q && frun_q;
    result_d  = seq_done ? sample_code : result_q;

    hold_d     = hold_q;
    hold_vld_d = hold_vld_q;
    if (rd_lo) begin
      hold_d     = result_q;
      hold_vld_d = 1'b1;
    end else if (rd_hi) begin
      hold_vld_d = 1'b0;
    end

    chan_act_d = seq_busy ? chan_act_q : chan_q;
    ref_act_d  = seq_busy ? ref_act_q  : ref_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q     <= '0;
      ref_q      <= 1'b0;
      ladj_q     <= 1'b0;
      frun_q     <= 1'b0;
      en_q       <= 1'b0;
      auto_q     <= 1'b0;
      flag_q     <= 1'b0;
      ie_q       <= 1'b0;
      ps_q       <= '0;
      trig_q     <= 1'b0;
      restart_q  <= 1'b0;
      result_q   <= '0;
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
      chan_act_q <= '0;
      ref_act_q  <= 1'b0;
    end else begin
      chan_q     <= chan_d;
      ref_q      <= ref_d;
      ladj_q     <= ladj_d;
      frun_q     <= frun_d;
      en_q       <= en_d;
      auto_q     <= auto_d;
      flag_q     <= flag_d;
      ie_q       <= ie_d;
      ps_q       <= ps_d;
      trig_q     <= trig_in;
      restart_q  <= restart_d;
      result_q   <= result_d;
      hold_q     <= hold_d;
      hold_vld_q <= hold_vld_d;
      chan_act_q <= chan_act_d;
      ref_act_q  <= ref_act_d;
    end
  end

  // read mux
  always_comb begin
    unique case (bus_addr)
      ADDR_SEL: bus_rdata = {3'b000, frun_q, ladj_q, ref_q, chan_q};
      ADDR_CTL: bus_rdata = {en_q, seq_busy, auto_q, flag_q, ie_q, ps_q};
      ADDR_DLO: bus_rdata = live_lo;
      default:  bus_rdata = hold_vld_q ? held_hi : live_hi;
    endcase
  end

  assign chan_sel = chan_act_q;
  assign ref_sel  = ref_act_q;
  assign irq      = flag_q && ie_q;

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> flag_q && (result_q == $past(sample_code)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && irq_ack && !seq_done |=> !flag_q);

  // R2
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> $stable(chan_sel) && $stable(ref_sel));

  // R6
  no_done_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !seq_done);

  // R12
  held_low_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld_q && !rd_lo |=> $stable(held_hi) || $changed(ladj_q));

  // held_lo is only formatted for symmetry with the live path
  held_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ladj_q |-> held_lo == hold_q[7:0]);

endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;

  logic       clk;
  logic       rst_n;
  logic       bus_wr, bus_rd;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       trig_in, irq_ack;
  logic [9:0] sample_code;
  logic [1:0] chan_sel;
  logic       ref_sel, irq;

  int errors = 0;
  int checks = 0;
  bit ended  = 0;

  adc_seq_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .trig_in     (trig_in),
    .irq_ack     (irq_ack),
    .sample_code (sample_code),
    .chan_sel    (chan_sel),
    .ref_sel     (ref_sel),
    .irq         (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 2'd1;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, int'(v), int'(exp));
  endtask

  // counts busy cycles starting at the current negedge
  task automatic measure(output int n);
    n = 0;
    bus_addr = 2'd1;
    #1;
    while (bus_rdata[6] && n < 3000) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  task automatic t_reset();
    check("R1 irq", int'(irq), 0);
    check("R1 chan_sel", int'(chan_sel), 0);
    check("R1 ref_sel", int'(ref_sel), 0);
    rd_check("R1 select", 2'd0, 8'h00);
    rd_check("R1 control", 2'd1, 8'h00);
    wr(2'd0, 8'hFF);
    rd_check("R1 reserved", 2'd0, 8'h1F);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_first_and_flag();
    int n;
    sample_code = 10'h2A5;
    wr(2'd1, 8'hC0);
    measure(n);
    check("R5 first length", n, 50);
    rd_check("R7 flag set", 2'd1, 8'h90);
    rd_check("R7 low byte", 2'd2, 8'hA5);
    rd_check("R7 high byte", 2'd3, 8'h02);
    wr(2'd1, 8'h80);
    rd_check("R8 write zero keeps", 2'd1, 8'h90);
    wr(2'd1, 8'h88);
    check("R7 irq", int'(irq), 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check("R8 ack irq", int'(irq), 0);
    rd_check("R8 ack flag", 2'd1, 8'h88);
    wr(2'd1, 8'h80);
  endtask

  task automatic t_left_adjust();
    wr(2'd0, 8'h08);
    rd_check("R3 left low", 2'd2, 8'h40);
    rd_check("R3 left high", 2'd3, 8'hA9);
    wr(2'd0, 8'h00);
    rd_check("R3 right low", 2'd2, 8'hA5);
    rd_check("R4 zero start", 2'd1, 8'h80);
  endtask

  task automatic t_codes();
    int n;
    sample_code = 10'h3FF;
    wr(2'd1, 8'hC0);
    measure(n);
    check("R5 normal length", n, 26);
    rd_check("R13 max low", 2'd2, 8'hFF);
    rd_check("R13 max high", 2'd3, 8'h03);
    wr(2'd1, 8'h90);
    rd_check("R8 write one clears", 2'd1, 8'h80);
    sample_code = 10'h000;
    wr(2'd1, 8'hC0);
    measure(n);
    rd_check("R13 zero low", 2'd2, 8'h00);
    rd_check("R13 zero high", 2'd3, 8'h00);
    wr(2'd1, 8'h90);
  endtask

  task automatic t_channel_hold();
    int n;
    wr(2'd0, 8'h01);
    sample_code = 10'h155;
    wr(2'd1, 8'hC0);
    check("R2 chan at start", int'(chan_sel), 1);
    wr(2'd0, 8'h06);
    check("R2 chan held", int'(chan_sel), 1);
    check("R2 ref held", int'(ref_sel), 0);
    rd_check("R2 readback", 2'd0, 8'h06);
    measure(n);
    check("R2 still old at end", int'(chan_sel), 1);
    @(negedge clk);
    check("R2 chan applied", int'(chan_sel), 2);
    check("R2 ref applied", int'(ref_sel), 1);
    wr(2'd1, 8'h90);
  endtask

  task automatic t_abort();
    int n;
    sample_code = 10'h0F0;
    wr(2'd1, 8'hC0);
    repeat (5) @(negedge clk);
    wr(2'd1, 8'h00);
    repeat (40) @(negedge clk);
    rd_check("R6 no flag", 2'd1, 8'h00);
    rd_check("R6 low kept", 2'd2, 8'h55);
    rd_check("R6 high kept", 2'd3, 8'h01);
    wr(2'd1, 8'hC0);
    measure(n);
    check("R5 first after re-enable", n, 50);
    rd_check("R7 new low", 2'd2, 8'hF0);
    wr(2'd1, 8'h90);
  endtask

  task automatic t_prescale();
    int n;
    wr(2'd1, 8'hC3);
    measure(n);
    check("R11 divide 8", n, 104);
    wr(2'd1, 8'hC1);
    measure(n);
    check("R11 divide 2 at code 1", n, 26);
    wr(2'd1, 8'hC5);
    measure(n);
    check("R11 divide 32", n, 416);
    wr(2'd1, 8'h90);
  endtask

  task automatic t_auto();
    int n;
    wr(2'd1, 8'hA0);
    rd_check("R9 idle before edge", 2'd1, 8'hA0);
    @(negedge clk); trig_in = 1'b1;
    @(negedge clk);
    measure(n);
    check("R9 trigger length", n, 26);
    repeat (10) @(negedge clk);
    rd_check("R9 no retrigger", 2'd1, 8'hB0);
    trig_in = 1'b0;
    wr(2'd1, 8'hB0);
    rd_check("R8 clear in auto", 2'd1, 8'hA0);
  endtask

  task automatic t_free_run();
    int n;
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h10);
    sample_code = 10'h2A5;
    wr(2'd1, 8'hE0);
    measure(n);
    check("R10 first free run", n, 50);
    @(negedge clk);
    measure(n);
    check("R10 restart length", n, 26);
    @(negedge clk);
    #1 check("R10 continues", int'(bus_rdata[6]), 1);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_freeze();
    int n;
    wr(2'd1, 8'h90);
    sample_code = 10'h1C3;
    wr(2'd1, 8'hC0);
    measure(n);
    rd_check("R12 low first", 2'd2, 8'hC3);
    sample_code = 10'h2A5;
    wr(2'd1, 8'hC0);
    measure(n);
    rd_check("R12 high frozen", 2'd3, 8'h01);
    rd_check("R12 high released", 2'd3, 8'h02);
    rd_check("R12 low live", 2'd2, 8'hA5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd1; bus_wdata = 8'h00;
    trig_in = 1'b0; irq_ack = 1'b0; sample_code = 10'h000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_and_flag();
    t_left_adjust();
    t_codes();
    t_channel_hold();
    t_abort();
    t_prescale();
    t_auto();
    t_free_run();
    t_freeze();
    finish_run();
  end

endmodule